// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block lets synchronous logic use an external asynchronous static RAM. The RAM has two chip selects of opposite polarity, active-low write and read strobes, and two active-low byte-lane enables. The host issues one request at a time. Each request carries an address, write data, a two-bit lane mask and a read/write flag. The host hands it over with a valid/ready handshake. Completion is marked by a one-clock done pulse, and for reads the captured data comes with that pulse.

Every access runs through four phases. In the first, address and chip selects are set up while the strobes stay inactive. The strobe is then held for `CYCLE_CLKS` clocks, which covers the RAM's 55 ns minimum cycle: with a 100 MHz clock that is 6 clocks. One hold clock follows with the strobes released and the address kept. The controller then parks the RAM in standby.

A static strap input selects the memory's organisation. In word mode the RAM is 16 bits wide. In byte mode it is 8 bits wide, and the topmost data line carries the highest address bit.

Top module: `sram_byte_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, the memory is deselected: `mem_ce1_n`=1, `mem_ce2`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_bhe_n`=`mem_ble_n`=1, `mem_dq_oe`=0, and `req_ready`=1.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from the clock after acceptance until the access has completed.
- R3: A write with a nonzero effective mask gives one clock of setup with the strobes inactive. `mem_we_n` is then low for exactly `CYCLE_CLKS` clocks with `mem_ce1_n`=0 and `mem_ce2`=1. In word mode, mask bit 0 drives `mem_ble_n` low (lines 7:0) and mask bit 1 drives `mem_bhe_n` low (lines 15:8).
- R4: A read drives `mem_oe_n` low for exactly `CYCLE_CLKS` clocks while `mem_we_n` stays high. Data is captured on the last of those clocks. In word mode a lane whose mask bit is 0 reads back as zero.
- R5: `rsp_done` is a single-clock pulse. It is high in the clock after the last strobe clock, which is `CYCLE_CLKS`+1 clocks after the acceptance edge, and `rsp_rdata` is valid with it.
- R6: The data drivers are enabled only for writes, from setup through hold. `mem_oe_n` is never low while any of lines 14:0 is driven.
- R7: With `byte_mode`=1:
  - `mem_addr` carries host address bits 20:0.
  - Line 15 is driven with host address bit 21 for the whole access.
  - Data moves on lines 7:0 and `rsp_rdata[15:8]` is zero.
  - Both lane enables are low while selected.
  - Only mask bit 0 counts.
- R8: A request whose effective mask is zero never selects the memory, never asserts `mem_we_n` or `mem_oe_n`, and completes with `rsp_done` one clock after acceptance.
- R9: In the clock after `rsp_done`, the memory is deselected again and `req_ready` is high.
- R10: `mem_addr` stays stable for as long as the memory is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_mode | input | 1 | Strap: 1 selects 8-bit organisation, 0 selects 16-bit |
| req_valid | input | 1 | Host request valid |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | AW+1 | Host address (word address in word mode, byte address in byte mode) |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask: bit 0 low byte, bit 1 high byte |
| req_ready | output | 1 | Controller idle and able to accept |
| rsp_rdata | output | 16 | Read data |
| rsp_done | output | 1 | One-clock completion pulse |
| mem_addr | output | AW | Memory address bus |
| mem_ce1_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_bhe_n | output | 1 | Active-low high-lane enable |
| mem_ble_n | output | 1 | Active-low low-lane enable |
| mem_dq_o | output | 16 | Data (and byte-mode address bit) toward memory |
| mem_dq_oe | output | 16 | Per-line tristate driver enable |
| mem_dq_i | input | 16 | Data from memory |

## Verification
The bench attacks the following corner cases:

- **Sampling window.** The memory model returns a garbage pattern whenever read conditions do not all hold. A controller that captured one clock late, after the read strobe rose, would return that pattern.
- **Partial lane masks.** Masks are mixed against a shadow copy. A wrong lane decode would either corrupt the neighbouring byte or leak stale data into a lane that should read as zero.
- **Zero-mask requests.** A design that still pulsed a strobe, or that reported completion late, is caught by strobe counting and latency checks.
- **Byte mode.** Reads and writes use one low address with both values of bit 21. A controller that failed to drive the top data line as an address would alias the two bytes. The bench also flags any clock in which the read strobe coincides with driven data lines.

// File: rtl/sram_byte_ctrl.sv
module sram_byte_ctrl #(
  parameter int CYCLE_CLKS = 6,
  parameter int AW         = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_mode,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW:0]   req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [1:0]    req_mask,
  output logic          req_ready,
  output logic [15:0]   rsp_rdata,
  output logic          rsp_done,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce1_n,
  output logic          mem_ce2,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_bhe_n,
  output logic          mem_ble_n,
  output logic [15:0]   mem_dq_o,
  output logic [15:0]   mem_dq_oe,
  input  logic [15:0]   mem_dq_i
);
  localparam int CNT_W = $clog2(CYCLE_CLKS + 1);

  typedef enum logic [1:0] {IDLE, SETUP, ACCESS, HOLD} phase_t;

  phase_t             ph;
  logic [CNT_W-1:0]   cnt;
  logic [AW:0]        a_q;
  logic [15:0]        d_q;
  logic [1:0]         lane_q;
  logic               wr_q;

  wire [1:0] lane_req = byte_mode ? {1'b0, req_mask[0]} : req_mask;
  wire       busy     = (ph != IDLE);

  assign req_ready = (ph == IDLE);
  assign mem_addr  = a_q[AW-1:0];
  assign mem_ce1_n = !busy;
  assign mem_ce2   = busy;
  assign mem_we_n  = !(ph == ACCESS && wr_q);
  assign mem_oe_n  = !(ph == ACCESS && !wr_q);
  assign mem_bhe_n = !(busy && (byte_mode || lane_q[1]));
  assign mem_ble_n = !(busy && (byte_mode || lane_q[0]));
  assign mem_dq_o  = byte_mode ? {a_q[AW], 7'h00, d_q[7:0]} : d_q;

  always_comb begin
    mem_dq_oe = 16'h0000;
    if (busy) begin
      if (wr_q)           mem_dq_oe = byte_mode ? 16'h80FF : 16'hFFFF;
      else if (byte_mode) mem_dq_oe = 16'h8000;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= IDLE;
      cnt       <= '0;
      a_q       <= '0;
      d_q       <= '0;
      lane_q    <= '0;
      wr_q      <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      case (ph)
        IDLE: if (req_valid) begin
          a_q    <= req_addr;
          d_q    <= req_wdata;
          wr_q   <= req_write;
          lane_q <= lane_req;
          if (lane_req == 2'b00) rsp_done <= 1'b1;
          else                   ph       <= SETUP;
        end
        SETUP: begin
          ph  <= ACCESS;
          cnt <= CNT_W'(CYCLE_CLKS - 1);
        end
        ACCESS: if (cnt == '0) begin
          ph       <= HOLD;
          rsp_done <= 1'b1;
          if (!wr_q)
            rsp_rdata <= byte_mode ? {8'h00, mem_dq_i[7:0]}
                       : {lane_q[1] ? mem_dq_i[15:8] : 8'h00,
                          lane_q[0] ? mem_dq_i[7:0]  : 8'h00};
        end else begin
          cnt <= cnt - 1'b1;
        end
        HOLD: ph <= IDLE;
        default: ph <= IDLE;
      endcase
    end
  end

  assert_idle_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n));

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  assert_strobe_selected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || !mem_oe_n) |-> (!mem_ce1_n && mem_ce2));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  assert_no_contention_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_dq_oe[14:0] == 15'h0));

  assert_back_to_standby_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> req_ready);

  assert_addr_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr));
endmodule

// File: tb/sram_byte_ctrl_tb.sv
module sram_byte_ctrl_tb;
  localparam int CYC = 6;
  localparam int AW  = 21;

  logic clk = 0, rst_n = 0, byte_mode = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic req_ready, rsp_done, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_bhe_n, mem_ble_n;
  logic [15:0] rsp_rdata, mem_dq_o, mem_dq_oe, mem_dq_i;
  logic [AW-1:0] mem_addr;

  int checks = 0, fails = 0, contention = 0;
  logic [15:0] mem_w [64];
  logic [7:0]  mem_b [128];
  logic [15:0] sh_w [64];
  logic [7:0]  sh_b [128];

  always #5 clk = ~clk;

  sram_byte_ctrl #(.CYCLE_CLKS(CYC), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .req_ready(req_ready), .rsp_rdata(rsp_rdata),
    .rsp_done(rsp_done), .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n),
    .mem_ce2(mem_ce2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_bhe_n(mem_bhe_n), .mem_ble_n(mem_ble_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i));

  wire sel   = !mem_ce1_n && mem_ce2;
  wire rd_ok = sel && !mem_oe_n && mem_we_n;
  wire [6:0] bidx = {mem_dq_o[15], mem_addr[5:0]};

  always_comb begin
    mem_dq_i = 16'hA5A5;
    if (rd_ok) begin
      if (byte_mode) mem_dq_i[7:0] = mem_b[bidx];
      else begin
        if (!mem_ble_n) mem_dq_i[7:0]  = mem_w[mem_addr[5:0]][7:0];
        if (!mem_bhe_n) mem_dq_i[15:8] = mem_w[mem_addr[5:0]][15:8];
      end
    end
  end

  always @(posedge clk) if (sel && !mem_we_n) begin
    if (byte_mode) mem_b[bidx] <= mem_dq_o[7:0];
    else begin
      if (!mem_ble_n) mem_w[mem_addr[5:0]][7:0]  <= mem_dq_o[7:0];
      if (!mem_bhe_n) mem_w[mem_addr[5:0]][15:8] <= mem_dq_o[15:8];
    end
  end

  always @(negedge clk) if (rst_n && !mem_oe_n && (mem_dq_oe[14:0] != 0)) contention++;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] eff(input logic bm, input logic [1:0] m);
    return bm ? {1'b0, m[0]} : m;
  endfunction

  function automatic logic [15:0] exp_read(input logic bm, input logic [AW:0] a, input logic [1:0] m);
    logic [1:0] e = eff(bm, m);
    if (bm) return e[0] ? {8'h00, sh_b[{a[AW], a[5:0]}]} : 16'h0000;
    return {e[1] ? sh_w[a[5:0]][15:8] : 8'h00, e[0] ? sh_w[a[5:0]][7:0] : 8'h00};
  endfunction

  task automatic shadow_write(input logic bm, input logic [AW:0] a, input logic [15:0] d, input logic [1:0] m);
    logic [1:0] e = eff(bm, m);
    if (bm) begin if (e[0]) sh_b[{a[AW], a[5:0]}] = d[7:0]; end
    else begin
      if (e[0]) sh_w[a[5:0]][7:0]  = d[7:0];
      if (e[1]) sh_w[a[5:0]][15:8] = d[15:8];
    end
  endtask

  task automatic xfer(input logic w, input logic [AW:0] a, input logic [15:0] d, input logic [1:0] m);
    int cyc = 0, we_cnt = 0, oe_cnt = 0;
    bit got = 0, bad_addr = 0, bad_ready = 0, bad_lane = 0, bad_oe = 0;
    logic [15:0] rd = '0, ex;
    logic [1:0] e = eff(byte_mode, m);
    ex = exp_read(byte_mode, a, m);
    @(negedge clk);
    check(req_ready, "R2 ready before request", req_ready, 1);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk);
    req_valid = 0;
    req_addr = ~a;
    while (!got && cyc < 40) begin
      if (!mem_we_n) we_cnt++;
      if (!mem_oe_n) oe_cnt++;
      if (sel) begin
        if (mem_addr != a[AW-1:0]) bad_addr = 1;
        if (byte_mode && (mem_dq_o[15] != a[AW] || !mem_dq_oe[15] || mem_bhe_n || mem_ble_n)) bad_lane = 1;
        if (!byte_mode && (mem_ble_n != !e[0] || mem_bhe_n != !e[1])) bad_lane = 1;
        if (w && mem_dq_oe[7:0] != 8'hFF) bad_oe = 1;
        if (!w && mem_dq_oe[14:0] != 0) bad_oe = 1;
      end
      if (rsp_done) begin got = 1; rd = rsp_rdata; end
      else begin
        if (req_ready) bad_ready = 1;
        @(negedge clk);
        cyc++;
      end
    end
    if (e == 2'b00) begin
      check(cyc == 0, "R8 zero-mask latency", cyc, 0);
      check(we_cnt == 0 && oe_cnt == 0, "R8 no strobe on zero mask", we_cnt + oe_cnt, 0);
      check(!bad_addr && !bad_lane, "R8 no select on zero mask", {bad_addr, bad_lane}, 0);
    end else begin
      check(cyc == CYC + 1, "R5 done latency", cyc, CYC + 1);
      check(!bad_ready, "R2 ready low while busy", bad_ready, 0);
      check(!bad_addr, "R10 address held", bad_addr, 0);
      check(!bad_lane, byte_mode ? "R7 byte-mode pins" : "R3 lane enables", bad_lane, 0);
      check(!bad_oe, "R6 driver enables", bad_oe, 0);
      if (w) check(we_cnt == CYC && oe_cnt == 0, "R3 write strobe width", {we_cnt[15:0], oe_cnt[15:0]}, {16'(CYC), 16'h0});
      else   check(oe_cnt == CYC && we_cnt == 0, "R4 read strobe width", {oe_cnt[15:0], we_cnt[15:0]}, {16'(CYC), 16'h0});
    end
    if (!w && got && e != 2'b00)
      check(rd == ex, byte_mode ? "R7 byte read data" : "R4 read data", rd, ex);
    if (w) shadow_write(byte_mode, a, d, m);
    @(negedge clk);
    check(!rsp_done && req_ready && mem_ce1_n && !mem_ce2, "R9 standby after done",
          {rsp_done, req_ready, mem_ce1_n, mem_ce2}, 4'b0110);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) begin mem_w[i] = 16'(i * 16'h0307 ^ 16'h5A3C); sh_w[i] = mem_w[i]; end
    for (int i = 0; i < 128; i++) begin mem_b[i] = 8'(i * 13 + 7); sh_b[i] = mem_b[i]; end
    repeat (3) @(negedge clk);
    check(mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && mem_bhe_n && mem_ble_n && mem_dq_oe == 0 && req_ready,
          "R1 reset state", {mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_bhe_n, mem_ble_n, req_ready}, 7'b1011111);
    rst_n = 1;
    xfer(1, 22'h000003, 16'h1234, 2'b11);
    xfer(0, 22'h000003, 16'h0000, 2'b11);
    xfer(1, 22'h000003, 16'hBEEF, 2'b10);
    xfer(0, 22'h000003, 16'h0000, 2'b11);
    xfer(0, 22'h000003, 16'h0000, 2'b01);
    xfer(0, 22'h000003, 16'h0000, 2'b10);
    xfer(1, 22'h000005, 16'hFFFF, 2'b00);
    xfer(0, 22'h000005, 16'h0000, 2'b11);
    xfer(0, 22'h000005, 16'h0000, 2'b00);
    for (int i = 0; i < 200; i++)
      xfer(1'($urandom), 22'($urandom), 16'($urandom), 2'($urandom));
    for (int i = 0; i < 64; i++) xfer(0, 22'(i), 16'h0, 2'b11);
    byte_mode = 1;
    @(negedge clk);
    xfer(1, 22'h000009, 16'h0011, 2'b01);
    xfer(1, 22'h200009, 16'h0022, 2'b01);
    xfer(0, 22'h000009, 16'h0000, 2'b11);
    xfer(0, 22'h200009, 16'h0000, 2'b01);
    xfer(1, 22'h000009, 16'h0099, 2'b10);
    xfer(0, 22'h000009, 16'h0000, 2'b01);
    for (int i = 0; i < 150; i++)
      xfer(1'($urandom), 22'($urandom), 16'($urandom), 2'($urandom));
    check(contention == 0, "R6 read strobe never with driven data lines", contention, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule